// File: doc/BRIEF.md
# Maskable CPU Interrupt Level Controller

This block sits beside a processor core and arbitrates sixteen maskable interrupt levels. Each level has a pending flag and an enable bit, and a single global mask bit gates the whole set. Hardware requests set flags. Each cycle the block compares the pending, enabled levels with the global mask and acknowledges the winner. On acknowledge it reports the level index to the core and updates the flag, enable and mask state in the same edge. Bits 0 to 13 carry the general levels, bit 14 the data-logging level and bit 15 the real-time operating system level. The non-maskable interrupt and the reset input are not handled here.

Software reaches the state through a synchronous register port. The port reads any register, sets enable bits by OR, clears enable bits by AND, clears flag bits by writing zero, and loads the global mask. The core can also inject two kinds of software interrupt. The intr kind behaves like a serviced hardware level. The trap kind only vectors: the level's flag and enable bits keep their values. The core holds off further acknowledges until it returns a done pulse.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, every flag and enable bit is 0, the global mask is 1 and `ack_valid` is 0.
- R2: A 1 on `hw_req[i]` sampled at a clock edge makes flag bit i read 1 from that edge on, until the flag bit is cleared.
- R3: Selecting the flag register (`acc_sel`=0) with the write operation (`acc_op`=3) clears every flag bit written 0 and keeps every flag bit written 1. A hardware request in the same cycle keeps its flag bit at 1. The OR (`acc_op`=1) and AND (`acc_op`=2) operations leave the flags unchanged.
- R4: Selecting the enable register (`acc_sel`=1) with `acc_op`=1 ORs `acc_wdata` into all 16 enable bits. With `acc_op`=2 it ANDs `acc_wdata` into all 16 bits. The write operation leaves the enable bits unchanged.
- R5: A hardware level is acknowledged only if its flag is 1, its enable is 1 and the global mask is 0 at the edge. A level whose enable is 0 is never acknowledged. A mask of 1 blocks every hardware level.
- R6: When several hardware levels qualify, the level with the lowest bit index wins.
- R7: A hardware acknowledge produces a one-cycle `ack_valid` pulse with `ack_vector` equal to the bit index. The same edge clears that level's flag and enable bits and sets the global mask to 1.
- R8: While an acknowledge is outstanding, no further acknowledge is produced. A 1 on `ack_done` ends the outstanding state, and the next acknowledge can come one cycle later.
- R9: An accepted intr-kind software request (`sw_req_kind`=0) acknowledges `sw_req_level` whatever its flag, its enable and the mask hold. It clears that level's flag and enable bits and sets the mask to 1.
- R10: An accepted trap-kind software request (`sw_req_kind`=1) acknowledges `sw_req_level` and sets the mask to 1. It leaves that level's flag and enable bits unchanged.
- R11: A software request made while an acknowledge is outstanding is dropped. When a software request and a qualifying hardware level meet in the same cycle, the software level is acknowledged and the hardware flag stays pending.
- R12: Selecting the mask (`acc_sel`=2) with `acc_op`=3 loads `acc_wdata[0]` into the mask. `acc_rdata` shows the selected register combinationally: the mask appears in bit 0 with zero above it, and `acc_sel`=3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_req | input | 16 | Hardware request per level |
| acc_sel | input | 2 | Register select: 0 flags, 1 enables, 2 mask, 3 none |
| acc_op | input | 2 | 0 read only, 1 OR-set, 2 AND-clear, 3 write |
| acc_wdata | input | 16 | Operand for the register operation |
| acc_rdata | output | 16 | Current value of the selected register |
| sw_req_valid | input | 1 | Software interrupt request |
| sw_req_kind | input | 1 | 0 intr kind, 1 trap kind |
| sw_req_level | input | 4 | Level index of the software request |
| ack_valid | output | 1 | One-cycle acknowledge pulse |
| ack_vector | output | 4 | Acknowledged level index |
| ack_done | input | 1 | Core has taken the outstanding acknowledge |

## Verification
The bench sets a request and a clearing flag write in the same cycle. A design that lets the clear win loses that interrupt. It checks that a trap leaves the enable bit standing while an intr clears it; mixing the two up either silences a level for good or makes it fire again. It drives a software and a hardware request together, and sends a software request while an acknowledge is still outstanding. A wrong arbiter there vectors to the wrong level or acknowledges twice. A sweep with all sixteen levels pending checks that the acknowledges come out in index order, once each, with `ack_done` freeing the next acknowledge on the following cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_SET   = 2'b01,
    ACC_CLR   = 2'b10,
    ACC_WRITE = 2'b11
  } acc_op_e;

  typedef enum logic [1:0] {
    SEL_FLAG   = 2'b00,
    SEL_ENABLE = 2'b01,
    SEL_MASK   = 2'b10,
    SEL_NONE   = 2'b11
  } acc_sel_e;

  typedef enum logic {
    SW_INTR = 1'b0,
    SW_TRAP = 1'b1
  } sw_kind_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_LEVELS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] set_i,
  input  logic                  wr_en_i,
  input  logic [NUM_LEVELS-1:0] wr_data_i,
  input  logic [NUM_LEVELS-1:0] ack_clr_i,
  output logic [NUM_LEVELS-1:0] flag_o
);

  logic [NUM_LEVELS-1:0] flag_q;
  logic [NUM_LEVELS-1:0] flag_d;
  logic                  flag_ce;

  // A write keeps only the bits written 1; new requests override every clear.
  always_comb begin
    flag_d = flag_q;
    if (wr_en_i) begin
      flag_d = flag_d & wr_data_i;
    end
    flag_d  = (flag_d & ~ack_clr_i) | set_i;
    flag_ce = wr_en_i | (|set_i) | (|ack_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_req_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  assert_write_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !(|ack_clr_i)) |=> ((flag_q & ~$past(wr_data_i) & ~$past(set_i)) == '0));

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int NUM_LEVELS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  or_en_i,
  input  logic                  and_en_i,
  input  logic [NUM_LEVELS-1:0] data_i,
  input  logic [NUM_LEVELS-1:0] ack_clr_i,
  output logic [NUM_LEVELS-1:0] en_o
);

  logic [NUM_LEVELS-1:0] en_q;
  logic [NUM_LEVELS-1:0] en_d;
  logic                  en_ce;

  // Software read-modify-write first, then the acknowledge clear on top.
  always_comb begin
    en_d = en_q;
    if (or_en_i) begin
      en_d = en_d | data_i;
    end
    if (and_en_i) begin
      en_d = en_d & data_i;
    end
    en_d  = en_d & ~ack_clr_i;
    en_ce = or_en_i | and_en_i | (|ack_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  assert_or_sets_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (or_en_i && !(|ack_clr_i)) |=> ((en_q & $past(data_i)) == $past(data_i)));

  assert_and_clears_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    and_en_i |=> ((en_q & ~$past(data_i)) == '0));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LEVELS = 16,
  localparam int VEC_W = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] req_i,
  output logic                  any_o,
  output logic [NUM_LEVELS-1:0] grant_o,
  output logic [VEC_W-1:0]      idx_o
);

  logic [NUM_LEVELS-1:0] lower_seen;

  // Prefix chain: a bit wins only if no lower-indexed bit is requesting.
  assign lower_seen[0] = 1'b0;
  for (genvar g = 1; g < NUM_LEVELS; g++) begin : g_chain
    assign lower_seen[g] = lower_seen[g-1] | req_i[g-1];
  end

  assign grant_o = req_i & ~lower_seen;
  assign any_o   = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (grant_o[i]) begin
        idx_o = idx_o | VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  localparam int VEC_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] hw_req,
  input  logic [1:0]            acc_sel,
  input  logic [1:0]            acc_op,
  input  logic [NUM_LEVELS-1:0] acc_wdata,
  output logic [NUM_LEVELS-1:0] acc_rdata,
  input  logic                  sw_req_valid,
  input  logic                  sw_req_kind,
  input  logic [VEC_W-1:0]      sw_req_level,
  output logic                  ack_valid,
  output logic [VEC_W-1:0]      ack_vector,
  input  logic                  ack_done
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // Access decode
  acc_op_e  op;
  acc_sel_e sel;
  logic     flag_wr;
  logic     en_or;
  logic     en_and;
  logic     mask_wr;

  always_comb begin
    op      = acc_op_e'(acc_op);
    sel     = acc_sel_e'(acc_sel);
    flag_wr = (sel == SEL_FLAG)   && (op == ACC_WRITE);
    en_or   = (sel == SEL_ENABLE) && (op == ACC_SET);
    en_and  = (sel == SEL_ENABLE) && (op == ACC_CLR);
    mask_wr = (sel == SEL_MASK)   && (op == ACC_WRITE);
  end

  // State
  logic [NUM_LEVELS-1:0] flag_q;
  logic [NUM_LEVELS-1:0] en_q;
  logic                  mask_q;
  logic                  busy_q;
  logic                  ack_valid_q;
  logic [VEC_W-1:0]      ack_vec_q;

  // Arbitration
  logic [NUM_LEVELS-1:0] eligible;
  logic                  pick_any;
  logic [NUM_LEVELS-1:0] pick_grant;
  logic [VEC_W-1:0]      pick_idx;

  assign eligible = flag_q & en_q & {NUM_LEVELS{~mask_q}};

  irq_prio_pick #(
    .NUM_LEVELS (NUM_LEVELS)
  ) u_pick (
    .req_i   (eligible),
    .any_o   (pick_any),
    .grant_o (pick_grant),
    .idx_o   (pick_idx)
  );

  logic [NUM_LEVELS-1:0] sw_onehot;
  logic                  sw_fire;
  logic                  hw_fire;
  logic                  ack_fire;
  logic [VEC_W-1:0]      ack_idx;
  logic [NUM_LEVELS-1:0] lvl_clr;

  always_comb begin
    sw_onehot               = '0;
    sw_onehot[sw_req_level] = 1'b1;
    sw_fire  = sw_req_valid & ~busy_q;
    hw_fire  = ~busy_q & ~sw_req_valid & pick_any;
    ack_fire = sw_fire | hw_fire;
    ack_idx  = sw_fire ? sw_req_level : pick_idx;
    if (hw_fire) begin
      lvl_clr = pick_grant;
    end else if (sw_fire && (sw_kind_e'(sw_req_kind) == SW_INTR)) begin
      lvl_clr = sw_onehot;
    end else begin
      lvl_clr = '0;
    end
  end

  irq_flag_bank #(
    .NUM_LEVELS (NUM_LEVELS)
  ) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (hw_req),
    .wr_en_i   (flag_wr),
    .wr_data_i (acc_wdata),
    .ack_clr_i (lvl_clr),
    .flag_o    (flag_q)
  );

  irq_enable_bank #(
    .NUM_LEVELS (NUM_LEVELS)
  ) u_enables (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .or_en_i   (en_or),
    .and_en_i  (en_and),
    .data_i    (acc_wdata),
    .ack_clr_i (lvl_clr),
    .en_o      (en_q)
  );

  // Mask, outstanding tracker and acknowledge output
  logic             mask_d;
  logic             mask_ce;
  logic             busy_d;
  logic             busy_ce;

  always_comb begin
    mask_ce = ack_fire | mask_wr;
    mask_d  = ack_fire ? 1'b1 : acc_wdata[0];
    busy_ce = ack_fire | ack_done;
    busy_d  = ack_fire;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= 1'b1;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
    end else if (busy_ce) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_valid_q <= 1'b0;
    end else begin
      ack_valid_q <= ack_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_vec_q <= '0;
    end else if (ack_fire) begin
      ack_vec_q <= ack_idx;
    end
  end

  assign ack_valid  = ack_valid_q;
  assign ack_vector = ack_vec_q;

  // Read path
  always_comb begin
    unique case (sel)
      SEL_FLAG:   acc_rdata = flag_q;
      SEL_ENABLE: acc_rdata = en_q;
      SEL_MASK:   acc_rdata = {{(NUM_LEVELS-1){1'b0}}, mask_q};
      default:    acc_rdata = '0;
    endcase
  end

  assert_hw_needs_eligible_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_q && !sw_req_valid && ((flag_q & en_q) == '0)) |=> !ack_valid);

  assert_mask_blocks_hw_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q && !sw_req_valid) |=> !ack_valid);

  assert_ack_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_valid |=> !ack_valid);

  assert_ack_sets_mask_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_valid |-> mask_q);

  assert_no_ack_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_q |=> !ack_valid);

  assert_ack_clears_enable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_valid && !$past(sw_req_valid && sw_req_kind)) |-> !en_q[ack_vector]);

  assert_trap_keeps_enable_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_req_valid && sw_req_kind && !busy_q && !en_and) |=> (en_q[$past(sw_req_level)] == $past(en_q[sw_req_level] | (en_or & acc_wdata[sw_req_level]))));

endmodule

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;

  typedef struct packed {
    logic [15:0] hw;
    logic [1:0]  sel;
    logic [1:0]  op;
    logic [15:0] wd;
    logic        swv;
    logic        swk;
    logic [3:0]  swl;
    logic        done;
    logic [15:0] eflag;
    logic [15:0] een;
    logic        emask;
    logic        eack;
    logic [3:0]  evec;
  } vec_t;

  localparam int NV = 27;

  // hw, sel, op, wdata, swv, swk, swl, done | flag, enable, mask, ack, vector
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 2'd1, 2'd1, 16'h0005, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h0005, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd1, 2'd1, 16'h800A, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h800F, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd1, 2'd2, 16'hFFF7, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h8007, 1'b1, 1'b0, 4'd0},
    '{16'h0006, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0006, 16'h8007, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd2, 2'd3, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0006, 16'h8007, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0004, 16'h8005, 1'b1, 1'b1, 4'd1},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0004, 16'h8005, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd2, 2'd3, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0004, 16'h8005, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h8001, 1'b1, 1'b1, 4'd2},
    '{16'h0008, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0008, 16'h8001, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd2, 2'd3, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0008, 16'h8001, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0008, 16'h8001, 1'b0, 1'b0, 4'd0},
    '{16'h0001, 2'd0, 2'd3, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0001, 16'h8001, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h8000, 1'b1, 1'b1, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b1, 1'b1, 4'd5,  1'b0, 16'h0000, 16'h8000, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0000, 16'h8000, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b1, 1'b1, 4'd15, 1'b0, 16'h0000, 16'h8000, 1'b1, 1'b1, 4'd15},
    '{16'h0000, 2'd1, 2'd1, 16'h0020, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0000, 16'h8020, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 4'd5,  1'b0, 16'h0000, 16'h8000, 1'b1, 1'b1, 4'd5},
    '{16'h0010, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0010, 16'h8000, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd1, 2'd1, 16'h0010, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0010, 16'h8010, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd2, 2'd3, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0010, 16'h8010, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 4'd14, 1'b0, 16'h0010, 16'h8010, 1'b1, 1'b1, 4'd14},
    '{16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b1, 16'h0010, 16'h8010, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd1, 16'hFFFF, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0010, 16'h8010, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd1, 2'd3, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0010, 16'h8010, 1'b1, 1'b0, 4'd0},
    '{16'h0000, 2'd0, 2'd3, 16'hFFEF, 1'b0, 1'b0, 4'd0,  1'b0, 16'h0000, 16'h8010, 1'b1, 1'b0, 4'd0}
  };

  function automatic string tag_of(int idx);
    case (idx)
      3, 11:          return "R5";
      4, 10, 21:      return "R12";
      5:              return "R6";
      6, 13:          return "R7";
      7, 8, 15, 23:   return "R8";
      9, 19:          return "R2";
      12, 24, 26:     return "R3";
      14, 22:         return "R11";
      16:             return "R10";
      18:             return "R9";
      default:        return "R4";
    endcase
  endfunction

  logic        clk;
  logic        rst_n;
  logic [15:0] hw_req;
  logic [1:0]  acc_sel;
  logic [1:0]  acc_op;
  logic [15:0] acc_wdata;
  logic [15:0] acc_rdata;
  logic        sw_req_valid;
  logic        sw_req_kind;
  logic [3:0]  sw_req_level;
  logic        ack_valid;
  logic [3:0]  ack_vector;
  logic        ack_done;

  int checks;
  int fails;
  bit finished;

  irq_level_ctrl u_irq_level_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_req       (hw_req),
    .acc_sel      (acc_sel),
    .acc_op       (acc_op),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .sw_req_valid (sw_req_valid),
    .sw_req_kind  (sw_req_kind),
    .sw_req_level (sw_req_level),
    .ack_valid    (ack_valid),
    .ack_vector   (ack_vector),
    .ack_done     (ack_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hw_req       = '0;
    acc_sel      = 2'd0;
    acc_op       = 2'd0;
    acc_wdata    = '0;
    sw_req_valid = 1'b0;
    sw_req_kind  = 1'b0;
    sw_req_level = '0;
    ack_done     = 1'b0;
  endtask

  // Reads every register through the port between edges and compares.
  task automatic observe(input string tag, input vec_t v);
    logic       got_ack;
    logic [3:0] got_vec;
    logic [15:0] r_flag;
    logic [15:0] r_en;
    logic [15:0] r_mask;
    got_ack = ack_valid;
    got_vec = ack_vector;
    acc_sel = 2'd0; #1 r_flag = acc_rdata;
    acc_sel = 2'd1; #1 r_en   = acc_rdata;
    acc_sel = 2'd2; #1 r_mask = acc_rdata;
    acc_sel = 2'd0;
    chk(tag, "flags",  r_flag, v.eflag);
    chk(tag, "enables", r_en, v.een);
    chk(tag, "mask",   r_mask, {15'b0, v.emask});
    chk(tag, "ack_valid", {15'b0, got_ack}, {15'b0, v.eack});
    if (v.eack) begin
      chk(tag, "ack_vector", {12'b0, got_vec}, {12'b0, v.evec});
    end
  endtask

  task automatic apply(input vec_t v, input string tag);
    @(negedge clk);
    hw_req       = v.hw;
    acc_sel      = v.sel;
    acc_op       = v.op;
    acc_wdata    = v.wd;
    sw_req_valid = v.swv;
    sw_req_kind  = v.swk;
    sw_req_level = v.swl;
    ack_done     = v.done;
    @(posedge clk);
    #1;
    idle_inputs();
    observe(tag, v);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    checks   = 0;
    fails    = 0;
    finished = 1'b0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state, and R12: unselected register reads zero
    v = '0;
    v.emask = 1'b1;
    observe("R1", v);
    acc_sel = 2'd3; #1;
    chk("R12", "unselected read", acc_rdata, 16'h0000);
    acc_sel = 2'd0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], tag_of(i));
    end

    // R1: asynchronous reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    v = '0;
    v.emask = 1'b1;
    observe("R1", v);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R6: all levels pending and enabled, drained one per acknowledge
    v = '0;
    v.hw = 16'hFFFF; v.sel = 2'd1; v.op = 2'd1; v.wd = 16'hFFFF;
    v.eflag = 16'hFFFF; v.een = 16'hFFFF; v.emask = 1'b1;
    apply(v, "R2");
    v = '0;
    v.sel = 2'd2; v.op = 2'd3;
    v.eflag = 16'hFFFF; v.een = 16'hFFFF; v.emask = 1'b0;
    apply(v, "R12");
    for (int i = 0; i < 16; i++) begin
      logic [15:0] rem;
      rem = 16'hFFFF << (i + 1);
      v = '0;
      v.eflag = rem; v.een = rem; v.emask = 1'b1; v.eack = 1'b1; v.evec = 4'(i);
      apply(v, "R6");
      v = '0;
      v.sel = 2'd2; v.op = 2'd3; v.done = 1'b1;
      v.eflag = rem; v.een = rem; v.emask = 1'b0;
      apply(v, "R8");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule